// File: doc/BRIEF.md
# Output Round, Format and Route Stage

This stage sits at the end of a two-leg filter datapath. Each cycle it may receive a sample from the upper processing leg and a sample from the lower processing leg, each with its own valid strobe. A 2-bit mode code and an interleave select decide which leg feeds each of the two 16-bit output words. In decimation the two legs are added. In complex output the legs stay apart. In interpolation the legs are merged into one stream or presented side by side.

Every word that is loaded first gets half of its target LSB added. The stage then clamps the result to the signed 16-bit range and clears the bits below the selected precision. Last, it can convert the word to offset binary. Both output words are registered, and each holds its value until a strobe loads a new one. The round code has no 13-bit or 15-bit setting, and one code forces the loaded words to zero.

Top module: `outq_format`

## Requirements
- R1: While rst_n is low, both a_word and b_word are 0x0000.
- R2: Every word is loaded one cycle after its strobe. The round code sets how many low bits are dropped: 000→8, 001→7, 010→6, 011→5, 100→4, 101→2, 110→0. Half of the kept LSB (1 << (drop-1)) is added before truncation, and the dropped low bits read as zero.
- R3: A word loaded while the round code is 111 is 0x0000 whatever the format select.
- R4: Saturation is applied after the rounding addition. A result above 32767 becomes 0x7FFF and one below -32768 becomes 0x8000, and the dropped low bits are cleared afterwards (for example 0x7F00 at 8 bits).
- R5: With fmt_ofs low the word is two's complement. With fmt_ofs high bit 15 of the rounded, saturated word is inverted (offset binary).
- R6: In mode 00, up_vld loads a_word from the sum up_data + lo_data, and b_word is 0x0000.
- R7: In mode 10, up_vld loads a_word from up_data and lo_vld loads b_word from lo_data, each on its own.
- R8: In modes 01 and 11 with merge_int high, up_vld loads a_word from up_data. lo_vld with up_vld low loads a_word from lo_data, and upper wins when both are high. b_word is 0x0000.
- R9: In modes 01 and 11 with merge_int low, a_word follows the upper leg and b_word follows the lower leg, as in R7.
- R10: A word whose load strobe is absent holds its value, even when data, round code or format change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_data | input | 16 | Upper-leg sample, signed |
| up_vld | input | 1 | Upper-leg sample strobe |
| lo_data | input | 16 | Lower-leg sample, signed |
| lo_vld | input | 1 | Lower-leg sample strobe |
| mode | input | 2 | Routing mode code |
| merge_int | input | 1 | 1: interleave legs onto A in interpolating modes |
| fmt_ofs | input | 1 | 0: two's complement, 1: offset binary |
| rnd_code | input | 3 | Precision select |
| a_word | output | 16 | Output word A |
| b_word | output | 16 | Output word B |

## Verification
On every cycle the assertions check several properties. The B word stays zero in the modes that leave it unused. The A word holds when no strobe arrives. The low byte is clear after an 8-bit load, and a zero-all load gives zero. A full-precision complex load passes the upper sample through with the selected sign coding. The exact rounded values come only from the bench scenarios. So do the saturation corners, the sum in decimation, the upper-leg priority when interleaving, and a B word that holds while its own strobe is absent.

// File: rtl/oq_pkg.sv
package oq_pkg;

    typedef enum logic [1:0] {
        MD_DECIM  = 2'b00,
        MD_INTERP = 2'b01,
        MD_CPLX   = 2'b10,
        MD_Q2R    = 2'b11
    } oq_mode_e;

    localparam logic [2:0] RC_ZERO = 3'b111;

    // number of low bits dropped for a round code in a word of width w
    function automatic int drop_bits(input logic [2:0] code, input int w);
        case (code)
            3'b000, 3'b001, 3'b010, 3'b011, 3'b100: drop_bits = w - 8 - int'(code);
            3'b101:  drop_bits = w - 14;
            default: drop_bits = 0;
        endcase
    endfunction

endpackage

// File: rtl/oq_route.sv
module oq_route #(
    parameter int W = 16
) (
    input  logic [W-1:0] up_data,
    input  logic         up_vld,
    input  logic [W-1:0] lo_data,
    input  logic         lo_vld,
    input  logic [1:0]   mode,
    input  logic         merge_int,
    output logic [W:0]   a_val,
    output logic         a_ld,
    output logic [W:0]   b_val,
    output logic         b_ld,
    output logic         b_idle
);
    import oq_pkg::*;

    logic [W:0] up_x, lo_x;

    assign up_x = {up_data[W-1], up_data};
    assign lo_x = {lo_data[W-1], lo_data};

    always_comb begin
        a_val  = up_x;
        a_ld   = up_vld;
        b_val  = lo_x;
        b_ld   = 1'b0;
        b_idle = 1'b1;
        case (oq_mode_e'(mode))
            MD_DECIM: begin
                a_val = up_x + lo_x;
            end
            MD_CPLX: begin
                b_ld   = lo_vld;
                b_idle = 1'b0;
            end
            default: begin
                if (merge_int) begin
                    a_ld  = up_vld | lo_vld;
                    a_val = up_vld ? up_x : lo_x;
                end else begin
                    b_ld   = lo_vld;
                    b_idle = 1'b0;
                end
            end
        endcase
    end

endmodule

// File: rtl/oq_shape.sv
module oq_shape #(
    parameter int W = 16
) (
    input  logic [W:0]   val,
    input  logic [2:0]   code,
    input  logic         fmt_ofs,
    output logic [W-1:0] word
);
    import oq_pkg::*;

    localparam logic signed [W+1:0] MAXV = (W+2)'((2 ** (W-1)) - 1);
    localparam logic signed [W+1:0] MINV = -(W+2)'(2 ** (W-1));

    logic signed [W+1:0] half, sum;
    logic [W-1:0]        clip;
    int                  k;

    always_comb begin
        k    = drop_bits(code, W);
        half = '0;
        for (int i = 0; i < W; i++) begin
            if (i == k - 1) half[i] = 1'b1;
        end
        sum = $signed({val[W], val}) + half;
        if (sum > MAXV)      clip = MAXV[W-1:0];
        else if (sum < MINV) clip = MINV[W-1:0];
        else                 clip = sum[W-1:0];
        for (int i = 0; i < W; i++) begin
            if (i < k) clip[i] = 1'b0;
        end
        if (fmt_ofs) clip[W-1] = ~clip[W-1];
        word = (code == RC_ZERO) ? '0 : clip;
    end

endmodule

// File: rtl/outq_format.sv
module outq_format #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] up_data,
    input  logic         up_vld,
    input  logic [W-1:0] lo_data,
    input  logic         lo_vld,
    input  logic [1:0]   mode,
    input  logic         merge_int,
    input  logic         fmt_ofs,
    input  logic [2:0]   rnd_code,
    output logic [W-1:0] a_word,
    output logic [W-1:0] b_word
);
    localparam int LANES = 2;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } out_t;

    out_t out_d, out_q;

    logic [W:0]   lane_val  [LANES];
    logic [W-1:0] lane_word [LANES];
    logic         a_ld, b_ld, b_idle;

    oq_route #(.W(W)) u_route (
        .up_data   (up_data),
        .up_vld    (up_vld),
        .lo_data   (lo_data),
        .lo_vld    (lo_vld),
        .mode      (mode),
        .merge_int (merge_int),
        .a_val     (lane_val[0]),
        .a_ld      (a_ld),
        .b_val     (lane_val[1]),
        .b_ld      (b_ld),
        .b_idle    (b_idle)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        oq_shape #(.W(W)) u_shape (
            .val     (lane_val[g]),
            .code    (rnd_code),
            .fmt_ofs (fmt_ofs),
            .word    (lane_word[g])
        );
    end

    always_comb begin
        out_d = out_q;
        if (a_ld)        out_d.a = lane_word[0];
        if (b_idle)      out_d.b = '0;
        else if (b_ld)   out_d.b = lane_word[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign a_word = out_q.a;
    assign b_word = out_q.b;

endmodule

// File: rtl/oq_chk.sv
module oq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] up_data,
    input logic         up_vld,
    input logic [W-1:0] lo_data,
    input logic         lo_vld,
    input logic [1:0]   mode,
    input logic         merge_int,
    input logic         fmt_ofs,
    input logic [2:0]   rnd_code,
    input logic [W-1:0] a_word,
    input logic [W-1:0] b_word
);
    // R6 R8
    b_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b00 || ($past(mode[0]) && $past(merge_int))) |-> b_word == '0);

    // R10
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(up_vld) && !$past(lo_vld)) |-> $stable(a_word));

    // R2
    low_byte_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_vld) && $past(rnd_code) == 3'b000) |-> a_word[7:0] == 8'h00);

    // R3
    zero_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_vld) && $past(rnd_code) == 3'b111) |-> a_word == '0);

    // R5
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_vld) && $past(mode) == 2'b10 && $past(rnd_code) == 3'b110)
        |-> a_word == {$past(up_data[W-1]) ^ $past(fmt_ofs), $past(up_data[W-2:0])});
endmodule

bind outq_format oq_chk #(.W(W)) u_chk (.*);

// File: tb/outq_format_test.sv
`timescale 1ns/1ps
module outq_format_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] up_data = '0, lo_data = '0;
    logic        up_vld = 1'b0, lo_vld = 1'b0;
    logic [1:0]  mode = 2'b10;
    logic        merge_int = 1'b0, fmt_ofs = 1'b0;
    logic [2:0]  rnd_code = 3'b110;
    logic [15:0] a_word, b_word;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    outq_format uut (.*);

    function automatic logic [15:0] model(input int v, input int code, input bit ofs);
        int k, r;
        logic [15:0] w;
        case (code)
            0: k = 8; 1: k = 7; 2: k = 6; 3: k = 5; 4: k = 4; 5: k = 2; default: k = 0;
        endcase
        if (code == 7) return 16'h0000;
        r = v + ((k > 0) ? (1 << (k - 1)) : 0);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        r = (r >>> k) << k;
        w = r[15:0];
        if (ofs) w[15] = ~w[15];
        return w;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic [15:0] u, input bit uv, input logic [15:0] l, input bit lv);
        @(negedge clk);
        up_data = u; up_vld = uv; lo_data = l; lo_vld = lv;
        @(negedge clk);
        up_vld = 1'b0; lo_vld = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R1 a", a_word, 16'h0000);
        check("R1 b", b_word, 16'h0000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_round;
        int vals[4] = '{4660, -4660, 1151, -129};
        mode = 2'b10; fmt_ofs = 1'b0;
        for (int c = 0; c < 7; c++) begin
            foreach (vals[j]) begin
                rnd_code = 3'(c);
                step(16'(vals[j]), 1'b1, 16'(vals[3-j]), 1'b1);
                check("R2 a", a_word, model(vals[j], c, 1'b0));
                check("R7 b", b_word, model(vals[3-j], c, 1'b0));
            end
        end
        rnd_code = 3'b111;
        step(16'h1234, 1'b1, 16'h8001, 1'b1);
        check("R3 a", a_word, 16'h0000);
        fmt_ofs = 1'b1;
        step(16'h5555, 1'b1, 16'h8000, 1'b1);
        check("R3 b ofs", b_word, 16'h0000);
        fmt_ofs = 1'b0;
    endtask

    task automatic t_sat;
        mode = 2'b10;
        rnd_code = 3'b000;
        step(16'h7FFF, 1'b1, 16'h8000, 1'b1);
        check("R4 pos", a_word, 16'h7F00);
        check("R4 neg", b_word, 16'h8000);
        rnd_code = 3'b101;
        step(16'h7FFE, 1'b1, 16'h8001, 1'b1);
        check("R4 14b", a_word, 16'h7FFC);
        check("R4 14b neg", b_word, 16'h8000);
        mode = 2'b00; rnd_code = 3'b110;
        step(16'h6000, 1'b1, 16'h6000, 1'b0);
        check("R4 sum pos", a_word, 16'h7FFF);
        step(16'h9000, 1'b1, 16'h9000, 1'b0);
        check("R4 sum neg", a_word, 16'h8000);
    endtask

    task automatic t_format;
        mode = 2'b10; fmt_ofs = 1'b1;
        rnd_code = 3'b110;
        step(16'h0000, 1'b1, 16'hFFFF, 1'b1);
        check("R5 zero", a_word, 16'h8000);
        check("R5 minus1", b_word, 16'h7FFF);
        rnd_code = 3'b001;
        step(16'(-300), 1'b1, 16'h7FFF, 1'b1);
        check("R5 round", a_word, model(-300, 1, 1'b1));
        check("R5 sat", b_word, 16'hFF80);
        fmt_ofs = 1'b0;
    endtask

    task automatic t_decim;
        mode = 2'b00; rnd_code = 3'b100;
        step(16'd1000, 1'b1, 16'(-37), 1'b1);
        check("R6 sum", a_word, model(963, 4, 1'b0));
        check("R6 b", b_word, 16'h0000);
        step(16'd50, 1'b0, 16'd77, 1'b1);
        check("R6 lo ignored", a_word, model(963, 4, 1'b0));
    endtask

    task automatic t_interleave;
        merge_int = 1'b1; rnd_code = 3'b110;
        for (int m = 1; m < 4; m += 2) begin
            mode = 2'(m);
            step(16'h0123, 1'b1, 16'h0456, 1'b0);
            check("R8 up", a_word, 16'h0123);
            step(16'h0AAA, 1'b0, 16'h0456, 1'b1);
            check("R8 lo", a_word, 16'h0456);
            step(16'h0777, 1'b1, 16'h0999, 1'b1);
            check("R8 prio", a_word, 16'h0777);
            check("R8 b", b_word, 16'h0000);
        end
    endtask

    task automatic t_external;
        merge_int = 1'b0; rnd_code = 3'b110;
        for (int m = 1; m < 4; m += 2) begin
            mode = 2'(m);
            step(16'h1111, 1'b1, 16'h2222, 1'b1);
            check("R9 a", a_word, 16'h1111);
            check("R9 b", b_word, 16'h2222);
            step(16'h3333, 1'b1, 16'h4444, 1'b0);
            check("R9 a only", a_word, 16'h3333);
            check("R10 b hold", b_word, 16'h2222);
        end
    endtask

    task automatic t_hold;
        mode = 2'b10; rnd_code = 3'b110;
        step(16'h4321, 1'b1, 16'h1234, 1'b1);
        rnd_code = 3'b000; fmt_ofs = 1'b1;
        step(16'h7777, 1'b0, 16'h6666, 1'b0);
        check("R10 a", a_word, 16'h4321);
        check("R10 b", b_word, 16'h1234);
        fmt_ofs = 1'b0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset;
        t_round;
        t_sat;
        t_format;
        t_decim;
        t_interleave;
        t_external;
        t_hold;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog got timeout expected completion");
        finish_run;
    end
endmodule